// File: doc/BRIEF.md
# Output Word Quantizer

This block takes the wide signed result at the end of a sample-rate-change filter chain and narrows it to the output word width. A per-sample mode input selects how the narrowing is done. The options are pass-through, plain truncation, round-half-to-even, round-half-up, and truncation followed by clamping to the output range.

The block has one register stage. A sample presented with its valid flag appears on the output one clock later. The channel number and the packet start and end markers travel with it through the same register. When valid is low, the output word holds its last value. The number of dropped low bits is a parameter. The kept field lies directly above the dropped bits.

Top module: `qz_out_quant`

## Requirements
- R1: After a synchronous active-high reset, `o_vld`, `o_sop`, `o_eop`, `o_chan` and `o_data` are all zero.
- R2: Mode code 1 (truncate) outputs the input bits `[DROP+W_OUT-1:DROP]` with no correction, which rounds toward minus infinity. Mode codes 5, 6 and 7 behave the same as code 1.
- R3: Mode code 2 (convergent) adds one to the kept field only when two conditions hold. First, the top dropped bit is 1. Second, either some lower dropped bit is 1 or the lowest kept bit is 1. An exact half therefore lands on an even value.
- R4: Mode code 3 (round-up) adds the top dropped bit into the kept field as a carry. This applies to negative and positive inputs alike.
- R5: Mode code 4 (saturate) drops the low bits and takes the signed kept field of width W_IN-DROP. If that field is above 2^(W_OUT-1)-1, the output is that maximum. If it is below -2^(W_OUT-1), the output is that minimum. Otherwise the output is the field's low W_OUT bits.
- R6: In modes 2 and 3, suppose the kept W_OUT-bit field already equals the largest positive output and an increment is due. The output then stays at that maximum instead of wrapping to the minimum.
- R7: Mode code 0 (pass-through) outputs the low W_OUT bits of the input unchanged. It is meant for W_OUT equal to W_IN.
- R8: The output data, channel, start and end markers appear exactly one cycle after the input sample. `o_vld` is `i_vld` delayed by one cycle.
- R9: A cycle with `i_vld` low does not change `o_data`, whatever the data input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_vld | input | 1 | Input sample valid |
| i_data | input | W_IN | Signed wide sample |
| i_chan | input | W_CH | Channel number of the sample |
| i_sop | input | 1 | First sample of a packet |
| i_eop | input | 1 | Last sample of a packet |
| i_mode | input | 3 | Quantization mode code |
| o_vld | output | 1 | Output valid |
| o_data | output | W_OUT | Quantized signed sample |
| o_chan | output | W_CH | Delayed channel number |
| o_sop | output | 1 | Delayed packet start |
| o_eop | output | 1 | Delayed packet end |

## Verification
Rounding and overflow protection can both act on the same sample. This happens when the kept field sits at the largest positive code and the dropped bits request an increment. The bench provokes it in the convergent and round-up modes with an odd maximum field and a half-way fraction. It expects the maximum, not the wrapped minimum. Exact-half ties are also driven with both even and odd kept fields, and with negative inputs, to separate the convergent rule from the round-up rule.

// File: rtl/qz_pkg.sv
package qz_pkg;
  typedef enum logic [2:0] {
    QZ_PASS  = 3'd0,
    QZ_TRUNC = 3'd1,
    QZ_CONV  = 3'd2,
    QZ_RUP   = 3'd3,
    QZ_SAT   = 3'd4
  } qz_mode_e;
endpackage

// File: rtl/qz_round.sv
// Rounding of the kept field: computes the increment and clamps at +max.
module qz_round #(
  parameter int W_OUT = 8,
  parameter int DROP  = 4
) (
  input  logic [W_OUT-1:0] kept,
  input  logic [DROP-1:0]  frac,
  input  logic             conv_sel,
  output logic [W_OUT-1:0] rounded
);
  localparam logic [W_OUT-1:0] POS_MAX = {1'b0, {(W_OUT-1){1'b1}}};
  localparam logic [DROP-1:0]  HALF    = DROP'(1) << (DROP-1);

  logic half_bit;
  logic below_half;
  logic inc;

  always_comb begin
    half_bit   = frac[DROP-1];
    below_half = |(frac & ~HALF);
    // convergent: tie goes to even; round-up: carry in the half bit
    inc = conv_sel ? (half_bit & (below_half | kept[0])) : half_bit;
    if (inc && kept == POS_MAX)
      rounded = POS_MAX;
    else
      rounded = kept + {{(W_OUT-1){1'b0}}, inc};
  end
endmodule

// File: rtl/qz_sat.sv
// Clamp a signed KW-bit field into the W_OUT-bit two's-complement range.
module qz_sat #(
  parameter int KW    = 12,
  parameter int W_OUT = 8
) (
  input  logic [KW-1:0]    field,
  output logic [W_OUT-1:0] limited
);
  localparam logic [W_OUT-1:0] POS_MAX = {1'b0, {(W_OUT-1){1'b1}}};
  localparam logic [W_OUT-1:0] NEG_MIN = {1'b1, {(W_OUT-1){1'b0}}};

  generate
    if (KW > W_OUT) begin : g_clip
      logic signed [KW-1:0] sfield;
      logic signed [KW-1:0] hi_lim;
      logic signed [KW-1:0] lo_lim;
      always_comb begin
        sfield = $signed(field);
        hi_lim = $signed({{(KW-W_OUT){1'b0}}, POS_MAX});
        lo_lim = $signed({{(KW-W_OUT){1'b1}}, NEG_MIN});
        if (sfield > hi_lim)
          limited = POS_MAX;
        else if (sfield < lo_lim)
          limited = NEG_MIN;
        else
          limited = field[W_OUT-1:0];
      end
    end else begin : g_fit
      always_comb limited = W_OUT'(field);
    end
  endgenerate
endmodule

// File: rtl/qz_out_quant.sv
module qz_out_quant #(
  parameter int W_IN  = 16,
  parameter int W_OUT = 8,
  parameter int DROP  = 4,
  parameter int W_CH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_vld,
  input  logic [W_IN-1:0]  i_data,
  input  logic [W_CH-1:0]  i_chan,
  input  logic             i_sop,
  input  logic             i_eop,
  input  logic [2:0]       i_mode,
  output logic             o_vld,
  output logic [W_OUT-1:0] o_data,
  output logic [W_CH-1:0]  o_chan,
  output logic             o_sop,
  output logic             o_eop
);
  import qz_pkg::*;

  localparam int KW = W_IN - DROP;
  localparam logic [W_OUT-1:0] POS_MAX = {1'b0, {(W_OUT-1){1'b1}}};
  localparam logic [W_OUT-1:0] NEG_MIN = {1'b1, {(W_OUT-1){1'b0}}};
  localparam logic [DROP-1:0]  HALF    = DROP'(1) << (DROP-1);

  qz_mode_e         mode;
  logic [KW-1:0]    field;
  logic [W_OUT-1:0] kept;
  logic [DROP-1:0]  frac;
  logic [W_OUT-1:0] rnd_val;
  logic [W_OUT-1:0] sat_val;
  logic [W_OUT-1:0] nxt_data;

  assign mode  = qz_mode_e'(i_mode);
  assign field = i_data[W_IN-1:DROP];
  assign kept  = i_data[DROP+W_OUT-1:DROP];
  assign frac  = i_data[DROP-1:0];

  qz_round #(.W_OUT(W_OUT), .DROP(DROP)) u_round (
    .kept     (kept),
    .frac     (frac),
    .conv_sel (mode == QZ_CONV),
    .rounded  (rnd_val)
  );

  qz_sat #(.KW(KW), .W_OUT(W_OUT)) u_sat (
    .field   (field),
    .limited (sat_val)
  );

  always_comb begin
    unique case (mode)
      QZ_PASS:         nxt_data = i_data[W_OUT-1:0];
      QZ_CONV, QZ_RUP: nxt_data = rnd_val;
      QZ_SAT:          nxt_data = sat_val;
      default:         nxt_data = kept;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld  <= 1'b0;
      o_data <= '0;
      o_chan <= '0;
      o_sop  <= 1'b0;
      o_eop  <= 1'b0;
    end else begin
      o_vld  <= i_vld;
      o_chan <= i_chan;
      o_sop  <= i_sop;
      o_eop  <= i_eop;
      if (i_vld) o_data <= nxt_data;
    end
  end

  // R8: valid follows the input one cycle later
  p_vld_delay_r8: assert property (@(posedge clk) disable iff (rst)
    i_vld |=> o_vld);
  // R9: idle cycles leave the output word alone
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !i_vld |=> $stable(o_data));
  // R2: truncation keeps the field above the dropped bits
  p_trunc_r2: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_mode == 3'd1) |=> o_data == $past(i_data[DROP+W_OUT-1:DROP]));
  // R5: positive overflow lands on the maximum
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_mode == 3'd4 && !i_data[W_IN-1] && |i_data[W_IN-1:DROP+W_OUT-1])
      |=> o_data == POS_MAX);
  // R5: negative overflow lands on the minimum
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_mode == 3'd4 && i_data[W_IN-1] && !(&i_data[W_IN-1:DROP+W_OUT-1]))
      |=> o_data == NEG_MIN);
  // R6: rounding never wraps past the maximum
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (i_vld && (i_mode == 3'd2 || i_mode == 3'd3) && kept == POS_MAX)
      |=> o_data == POS_MAX);
  // R3: an exact half rounds to an even result
  p_tie_even_r3: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_mode == 3'd2 && frac == HALF && kept != POS_MAX) |=> !o_data[0]);
endmodule

// File: tb/sim_qz_out_quant.sv
`timescale 1ns/1ps
module sim_qz_out_quant;
  localparam int W_IN = 16, W_OUT = 8, DROP = 4, W_CH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             i_vld = 1'b0;
  logic [W_IN-1:0]  i_data = '0;
  logic [W_CH-1:0]  i_chan = '0;
  logic             i_sop = 1'b0;
  logic             i_eop = 1'b0;
  logic [2:0]       i_mode = 3'd0;
  logic             o_vld;
  logic [W_OUT-1:0] o_data;
  logic [W_CH-1:0]  o_chan;
  logic             o_sop;
  logic             o_eop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qz_out_quant #(.W_IN(W_IN), .W_OUT(W_OUT), .DROP(DROP), .W_CH(W_CH)) u0 (
    .clk(clk), .rst(rst), .i_vld(i_vld), .i_data(i_data), .i_chan(i_chan),
    .i_sop(i_sop), .i_eop(i_eop), .i_mode(i_mode), .o_vld(o_vld),
    .o_data(o_data), .o_chan(o_chan), .o_sop(o_sop), .o_eop(o_eop));

  // expected value from the requirement text
  function automatic logic [7:0] expect_q(logic [15:0] x, logic [2:0] m);
    logic signed [15:0] sx;
    logic signed [15:0] k;
    logic [3:0] fr;
    logic inc;
    sx = x;
    k = sx >>> 4;
    fr = x[3:0];
    inc = 1'b0;
    case (m)
      3'd0: return x[7:0];
      3'd2: inc = fr[3] && ((fr[2:0] != 3'd0) || k[0]);
      3'd3: inc = fr[3];
      3'd4: begin
        if (k > 16'sd127) return 8'h7f;
        if (k < -16'sd128) return 8'h80;
        return k[7:0];
      end
      default: inc = 1'b0;
    endcase
    if (inc && k[7:0] == 8'h7f) return 8'h7f;
    return k[7:0] + {7'd0, inc};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] x, logic [2:0] m, logic [3:0] ch, logic s, logic e);
    @(negedge clk);
    i_vld = 1'b1; i_data = x; i_mode = m; i_chan = ch; i_sop = s; i_eop = e;
    @(negedge clk);
    i_vld = 1'b0; i_sop = 1'b0; i_eop = 1'b0;
  endtask

  task automatic run_one(string req, logic [15:0] x, logic [2:0] m);
    send(x, m, 4'd0, 1'b0, 1'b0);
    check(req, {24'd0, o_data}, {24'd0, expect_q(x, m)});
  endtask

  task automatic t_reset();
    check("R1", {27'd0, o_vld, o_sop, o_eop, 2'd0}, 32'd0);
    check("R1", {20'd0, o_chan, o_data}, 32'd0);
  endtask

  task automatic t_trunc();
    run_one("R2", 16'h0018, 3'd1);
    run_one("R2", 16'hFFE8, 3'd1);
    check("R2", {24'd0, o_data}, 32'h000000FE);
    run_one("R2", 16'h123F, 3'd6);
    check("R2", {24'd0, o_data}, 32'h00000023);
  endtask

  task automatic t_conv();
    run_one("R3", 16'h0018, 3'd2);
    check("R3", {24'd0, o_data}, 32'h00000002);
    run_one("R3", 16'h0028, 3'd2);
    check("R3", {24'd0, o_data}, 32'h00000002);
    run_one("R3", 16'h0029, 3'd2);
    run_one("R3", 16'hFFE8, 3'd2);
    check("R3", {24'd0, o_data}, 32'h000000FE);
    run_one("R3", 16'h0027, 3'd2);
  endtask

  task automatic t_rup();
    run_one("R4", 16'h0028, 3'd3);
    check("R4", {24'd0, o_data}, 32'h00000003);
    run_one("R4", 16'hFFE8, 3'd3);
    check("R4", {24'd0, o_data}, 32'h000000FF);
    run_one("R4", 16'hFFF7, 3'd3);
  endtask

  task automatic t_sat();
    run_one("R5", 16'h1230, 3'd4);
    check("R5", {24'd0, o_data}, 32'h0000007F);
    run_one("R5", 16'hE000, 3'd4);
    check("R5", {24'd0, o_data}, 32'h00000080);
    run_one("R5", 16'h0500, 3'd4);
    run_one("R5", 16'hF805, 3'd4);
  endtask

  task automatic t_clamp();
    run_one("R6", 16'h07F8, 3'd2);
    check("R6", {24'd0, o_data}, 32'h0000007F);
    run_one("R6", 16'h07FC, 3'd3);
    check("R6", {24'd0, o_data}, 32'h0000007F);
  endtask

  task automatic t_pass();
    run_one("R7", 16'h1234, 3'd0);
    check("R7", {24'd0, o_data}, 32'h00000034);
  endtask

  task automatic t_sideband();
    @(negedge clk);
    i_vld = 1'b1; i_data = 16'h0040; i_mode = 3'd1; i_chan = 4'hA;
    i_sop = 1'b1; i_eop = 1'b0;
    check("R8", {31'd0, o_vld}, 32'd0);
    @(negedge clk);
    check("R8", {20'd0, o_chan, o_data}, {20'd0, 4'hA, 8'h04});
    check("R8", {29'd0, o_vld, o_sop, o_eop}, 32'b110);
    i_data = 16'h0050; i_chan = 4'h3; i_sop = 1'b0; i_eop = 1'b1;
    @(negedge clk);
    check("R8", {20'd0, o_chan, o_data}, {20'd0, 4'h3, 8'h05});
    check("R8", {29'd0, o_vld, o_sop, o_eop}, 32'b101);
    i_vld = 1'b0; i_eop = 1'b0;
    @(negedge clk);
    check("R8", {31'd0, o_vld}, 32'd0);
  endtask

  task automatic t_idle();
    send(16'h0070, 3'd1, 4'd1, 1'b0, 1'b0);
    check("R9", {24'd0, o_data}, 32'h00000007);
    i_data = 16'h7FFF; i_mode = 3'd4;
    repeat (3) @(negedge clk);
    check("R9", {24'd0, o_data}, 32'h00000007);
    check("R9", {31'd0, o_vld}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_trunc();
    t_conv();
    t_rup();
    t_sat();
    t_clamp();
    t_pass();
    t_sideband();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule